// File: doc/BRIEF.md
# Ferroelectric RAM identification sequencer

This block runs once after power-up, or whenever software-independent start logic pulses `start`, to find out what kind of ferroelectric RAM sits on an SPI bus and how large it is. It acts as the bus master in mode 0: the clock idles low, data leaves MSB first, and the device output is sampled on the rising clock edge. The block first reads the device status byte. It then reads the nine-byte identity string. If the identity string says so, it finally reads the eight-byte serial number.

From the identity string it checks the vendor code and decodes the density code. From these it produces the array capacity in bytes and the number of address bytes that later memory commands must carry. A probe that fails stops early and reports why through a two-bit fault code. A successful probe raises `probe_ok`. All results hold until the next `start`.

Top module: `fram_probe`

## Requirements
- R1: After reset, `spi_cs_n`=1, `spi_sclk`=0, `probe_done`=0, `probe_ok`=0, `fault_code`=0, `capacity`=0, `addr_bytes`=0, `sn_present`=0 and `serial_num`=0.
- R2: A `start` pulse while idle opens a chip-select window that shifts out opcode 0x05 (MSB first, mode 0) and then reads one response byte. `spi_sclk` only toggles while `spi_cs_n` is low.
- R3: If bit 0 of the status byte is 1, the probe ends with `fault_code`=1 and `probe_ok`=0, and no further window is opened. Other status bits have no effect.
- R4: Otherwise a second window shifts out opcode 0x9F and reads 9 identity bytes, numbered 0 to 8 in arrival order.
- R5: If identity byte 6 is not 0xC2, the probe ends with `fault_code`=2. This check has priority over R6.
- R6: If identity byte 7 is below 0x21 or above 0x26, the probe ends with `fault_code`=3.
- R7: On a good identity, `capacity` = 2^(byte7 − 0x21 + 4) × 1024, which ranges from 16384 to 524288.
- R8: `addr_bytes` is 3 when `capacity` exceeds 65536, and 2 otherwise.
- R9: If identity byte 8 is nonzero, a third window shifts out opcode 0xC3 and reads 8 bytes, and `sn_present` is set to 1. `serial_num[8k+7:8k]` holds the byte that arrived at position 7−k, so the first byte received lands in bits 63:56.
- R10: If identity byte 8 is zero, no third window is opened, `sn_present`=0 and `serial_num`=0, even after an earlier probe that found a serial number.
- R11: At the end of a probe, `probe_done` rises and `probe_ok` = (`fault_code`==0). All results then hold until the next `start`. A `start` during a probe is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a probe (taken while idle) |
| spi_sclk | output | 1 | SPI serial clock, idles low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Device data in |
| probe_done | output | 1 | Probe finished; results are valid |
| probe_ok | output | 1 | Probe finished without a fault |
| fault_code | output | 2 | 0 none, 1 busy, 2 wrong vendor, 3 unsupported density |
| capacity | output | 20 | Array size in bytes |
| addr_bytes | output | 2 | Address bytes needed by memory commands (2 or 3) |
| sn_present | output | 1 | Serial number was read |
| serial_num | output | 64 | Serial number, stored in reversed arrival order |

## Verification
The checker assumes that `spi_miso` changes only while `spi_sclk` is low, so the rising-edge sample is never taken on a changing bit. It also assumes that `start` is a synchronous pulse. The bench's device model moves MISO only on falling clock edges and after chip select falls. It drives `start` as single-cycle pulses from the falling edge of the system clock. The model logs every chip-select window, its opcode and its byte count, so the bench can check both which windows happened and which were skipped.

// File: rtl/fram_probe_pkg.sv
package fram_probe_pkg;
   localparam logic [7:0] CMD_STAT   = 8'h05;
   localparam logic [7:0] CMD_IDENT  = 8'h9F;
   localparam logic [7:0] CMD_SERIAL = 8'hC3;

   typedef enum logic [1:0] {
      FAULT_NONE   = 2'd0,
      FAULT_BUSY   = 2'd1,
      FAULT_VENDOR = 2'd2,
      FAULT_SIZE   = 2'd3
   } fault_e;

   typedef enum logic [1:0] {
      STEP_STAT   = 2'd0,
      STEP_IDENT  = 2'd1,
      STEP_SERIAL = 2'd2
   } step_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_SELECT,
      SQ_SHIFT,
      SQ_WAIT,
      SQ_RELEASE,
      SQ_EVAL
   } sq_e;
endpackage

// File: rtl/fram_probe_shifter.sv
module fram_probe_shifter #(
   parameter int HALF = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] tx_byte,
   output logic       sclk,
   output logic       mosi,
   input  logic       miso,
   output logic [7:0] rx_byte,
   output logic       byte_done
);
   localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

   logic          active_q;
   logic [CW-1:0] div_q;
   logic [2:0]    bit_q;
   logic [7:0]    tx_sh;
   logic [7:0]    rx_sh;
   logic          sclk_q;
   logic          done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         div_q    <= '0;
         bit_q    <= '0;
         tx_sh    <= '0;
         rx_sh    <= '0;
         sclk_q   <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!active_q) begin
            if (go) begin
               active_q <= 1'b1;
               tx_sh    <= tx_byte;
               bit_q    <= '0;
               div_q    <= '0;
               sclk_q   <= 1'b0;
            end
         end else if (div_q == CW'(HALF - 1)) begin
            div_q <= '0;
            if (!sclk_q) begin
               sclk_q <= 1'b1;
               rx_sh  <= {rx_sh[6:0], miso};
            end else begin
               sclk_q <= 1'b0;
               if (bit_q == 3'd7) begin
                  active_q <= 1'b0;
                  done_q   <= 1'b1;
               end else begin
                  bit_q <= bit_q + 3'd1;
                  tx_sh <= {tx_sh[6:0], 1'b0};
               end
            end
         end else begin
            div_q <= div_q + CW'(1);
         end
      end
   end

   assign sclk      = sclk_q;
   assign mosi      = tx_sh[7];
   assign rx_byte   = rx_sh;
   assign byte_done = done_q;
endmodule

// File: rtl/fram_probe_geom.sv
module fram_probe_geom #(
   parameter logic [7:0] VENDOR    = 8'hC2,
   parameter logic [7:0] DENS_LO   = 8'h21,
   parameter logic [7:0] DENS_HI   = 8'h26,
   parameter int         BASE_LOG2 = 14,
   parameter int         WIDE_LOG2 = 16,
   parameter int         CAP_W     = 20
) (
   input  logic [7:0]       vendor_byte,
   input  logic [7:0]       dens_byte,
   output logic             vendor_ok,
   output logic             dens_ok,
   output logic [CAP_W-1:0] cap_bytes,
   output logic             wide_addr
);
   logic [7:0] log2_sz;

   always_comb begin
      vendor_ok = (vendor_byte == VENDOR);
      dens_ok   = (dens_byte >= DENS_LO) && (dens_byte <= DENS_HI);
      log2_sz   = dens_byte - DENS_LO + 8'(BASE_LOG2);
      cap_bytes = '0;
      wide_addr = 1'b0;
      if (dens_ok) begin
         cap_bytes = CAP_W'(1) << log2_sz;
         wide_addr = (log2_sz > 8'(WIDE_LOG2));
      end
   end
endmodule

// File: rtl/fram_probe_seq.sv
module fram_probe_seq
   import fram_probe_pkg::*;
#(
   parameter int ID_LEN   = 9,
   parameter int SN_LEN   = 8,
   parameter int CS_GAP   = 4,
   parameter int VEND_IDX = 6,
   parameter int DENS_IDX = 7,
   parameter int SNF_IDX  = 8,
   parameter int CAP_W    = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   output logic               eng_go,
   output logic [7:0]         eng_tx,
   input  logic               eng_done,
   input  logic [7:0]         eng_rx,
   output logic               cs_n,
   output logic [7:0]         vendor_byte,
   output logic [7:0]         dens_byte,
   input  logic               vendor_ok,
   input  logic               dens_ok,
   input  logic [CAP_W-1:0]   cap_in,
   input  logic               wide_in,
   output logic               done,
   output logic               ok,
   output logic [1:0]         fault,
   output logic [CAP_W-1:0]   capacity,
   output logic [1:0]         addr_bytes,
   output logic               sn_present,
   output logic [8*SN_LEN-1:0] serial
);
   localparam int BUF_N = (ID_LEN > SN_LEN) ? ID_LEN : SN_LEN;
   localparam int IW    = $clog2(BUF_N + 1);
   localparam int GW    = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;

   sq_e                 st_q;
   step_e               step_q;
   logic [IW-1:0]       idx_q;
   logic [GW-1:0]       gap_q;
   logic [7:0]          rbuf [BUF_N];
   logic [IW-1:0]       nbytes;
   logic [7:0]          opcode;
   logic [8*SN_LEN-1:0] sn_rev;
   logic                go_q;
   logic [7:0]          tx_q;
   logic                cs_q;

   always_comb begin
      case (step_q)
         STEP_STAT:  begin nbytes = IW'(1);      opcode = CMD_STAT;   end
         STEP_IDENT: begin nbytes = IW'(ID_LEN); opcode = CMD_IDENT;  end
         default:    begin nbytes = IW'(SN_LEN); opcode = CMD_SERIAL; end
      endcase
   end

   for (genvar k = 0; k < SN_LEN; k++) begin : g_rev
      assign sn_rev[8*k +: 8] = rbuf[SN_LEN-1-k];
   end

   for (genvar j = 0; j < BUF_N; j++) begin : g_cap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rbuf[j] <= '0;
         else if (st_q == SQ_WAIT && eng_done && idx_q == IW'(j + 1))
            rbuf[j] <= eng_rx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= SQ_IDLE;
         step_q     <= STEP_STAT;
         idx_q      <= '0;
         gap_q      <= '0;
         go_q       <= 1'b0;
         tx_q       <= '0;
         cs_q       <= 1'b1;
         done       <= 1'b0;
         ok         <= 1'b0;
         fault      <= FAULT_NONE;
         capacity   <= '0;
         addr_bytes <= '0;
         sn_present <= 1'b0;
         serial     <= '0;
      end else begin
         go_q <= 1'b0;
         case (st_q)
            SQ_IDLE: begin
               if (start) begin
                  done       <= 1'b0;
                  ok         <= 1'b0;
                  fault      <= FAULT_NONE;
                  capacity   <= '0;
                  addr_bytes <= '0;
                  sn_present <= 1'b0;
                  serial     <= '0;
                  step_q     <= STEP_STAT;
                  st_q       <= SQ_SELECT;
               end
            end
            SQ_SELECT: begin
               cs_q  <= 1'b0;
               idx_q <= '0;
               st_q  <= SQ_SHIFT;
            end
            SQ_SHIFT: begin
               go_q <= 1'b1;
               tx_q <= (idx_q == '0) ? opcode : 8'h00;
               st_q <= SQ_WAIT;
            end
            SQ_WAIT: begin
               if (eng_done) begin
                  if (idx_q == nbytes) begin
                     cs_q  <= 1'b1;
                     gap_q <= '0;
                     st_q  <= SQ_RELEASE;
                  end else begin
                     idx_q <= idx_q + IW'(1);
                     st_q  <= SQ_SHIFT;
                  end
               end
            end
            SQ_RELEASE: begin
               if (gap_q == GW'(CS_GAP - 1))
                  st_q <= SQ_EVAL;
               else
                  gap_q <= gap_q + GW'(1);
            end
            SQ_EVAL: begin
               case (step_q)
                  STEP_STAT: begin
                     if (rbuf[0][0]) begin
                        fault <= FAULT_BUSY;
                        done  <= 1'b1;
                        st_q  <= SQ_IDLE;
                     end else begin
                        step_q <= STEP_IDENT;
                        st_q   <= SQ_SELECT;
                     end
                  end
                  STEP_IDENT: begin
                     if (!vendor_ok) begin
                        fault <= FAULT_VENDOR;
                        done  <= 1'b1;
                        st_q  <= SQ_IDLE;
                     end else if (!dens_ok) begin
                        fault <= FAULT_SIZE;
                        done  <= 1'b1;
                        st_q  <= SQ_IDLE;
                     end else begin
                        capacity   <= cap_in;
                        addr_bytes <= wide_in ? 2'd3 : 2'd2;
                        if (rbuf[SNF_IDX] != 8'h00) begin
                           sn_present <= 1'b1;
                           step_q     <= STEP_SERIAL;
                           st_q       <= SQ_SELECT;
                        end else begin
                           ok   <= 1'b1;
                           done <= 1'b1;
                           st_q <= SQ_IDLE;
                        end
                     end
                  end
                  default: begin
                     serial <= sn_rev;
                     ok     <= 1'b1;
                     done   <= 1'b1;
                     st_q   <= SQ_IDLE;
                  end
               endcase
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign eng_go      = go_q;
   assign eng_tx      = tx_q;
   assign cs_n        = cs_q;
   assign vendor_byte = rbuf[VEND_IDX];
   assign dens_byte   = rbuf[DENS_IDX];
endmodule

// File: rtl/fram_probe.sv
module fram_probe
   import fram_probe_pkg::*;
#(
   parameter int         CLK_DIV   = 2,
   parameter int         CS_GAP    = 4,
   parameter int         ID_LEN    = 9,
   parameter int         SN_LEN    = 8,
   parameter logic [7:0] VENDOR    = 8'hC2,
   parameter logic [7:0] DENS_LO   = 8'h21,
   parameter logic [7:0] DENS_HI   = 8'h26,
   parameter int         BASE_LOG2 = 14,
   parameter int         WIDE_LOG2 = 16,
   parameter int         CAP_W     = DENS_HI - DENS_LO + BASE_LOG2 + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   output logic                 spi_sclk,
   output logic                 spi_cs_n,
   output logic                 spi_mosi,
   input  logic                 spi_miso,
   output logic                 probe_done,
   output logic                 probe_ok,
   output logic [1:0]           fault_code,
   output logic [CAP_W-1:0]     capacity,
   output logic [1:0]           addr_bytes,
   output logic                 sn_present,
   output logic [8*SN_LEN-1:0]  serial_num
);
   localparam int VEND_IDX = 6;
   localparam int DENS_IDX = 7;
   localparam int SNF_IDX  = 8;

   if (CLK_DIV < 1) begin : g_bad_div
      $error("CLK_DIV must be at least 1");
   end
   if (CS_GAP < 1) begin : g_bad_gap
      $error("CS_GAP must be at least 1");
   end
   if (ID_LEN <= SNF_IDX) begin : g_bad_id
      $error("ID_LEN too short for the flag byte");
   end
   if (DENS_HI < DENS_LO) begin : g_bad_dens
      $error("density range is empty");
   end

   logic             eng_go;
   logic [7:0]       eng_tx;
   logic             eng_done;
   logic [7:0]       eng_rx;
   logic [7:0]       vendor_byte;
   logic [7:0]       dens_byte;
   logic             vendor_ok;
   logic             dens_ok;
   logic [CAP_W-1:0] cap_w;
   logic             wide_w;

   fram_probe_shifter #(.HALF(CLK_DIV)) shifter_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (eng_go),
      .tx_byte   (eng_tx),
      .sclk      (spi_sclk),
      .mosi      (spi_mosi),
      .miso      (spi_miso),
      .rx_byte   (eng_rx),
      .byte_done (eng_done)
   );

   fram_probe_geom #(
      .VENDOR    (VENDOR),
      .DENS_LO   (DENS_LO),
      .DENS_HI   (DENS_HI),
      .BASE_LOG2 (BASE_LOG2),
      .WIDE_LOG2 (WIDE_LOG2),
      .CAP_W     (CAP_W)
   ) geom_i (
      .vendor_byte (vendor_byte),
      .dens_byte   (dens_byte),
      .vendor_ok   (vendor_ok),
      .dens_ok     (dens_ok),
      .cap_bytes   (cap_w),
      .wide_addr   (wide_w)
   );

   fram_probe_seq #(
      .ID_LEN   (ID_LEN),
      .SN_LEN   (SN_LEN),
      .CS_GAP   (CS_GAP),
      .VEND_IDX (VEND_IDX),
      .DENS_IDX (DENS_IDX),
      .SNF_IDX  (SNF_IDX),
      .CAP_W    (CAP_W)
   ) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .eng_go      (eng_go),
      .eng_tx      (eng_tx),
      .eng_done    (eng_done),
      .eng_rx      (eng_rx),
      .cs_n        (spi_cs_n),
      .vendor_byte (vendor_byte),
      .dens_byte   (dens_byte),
      .vendor_ok   (vendor_ok),
      .dens_ok     (dens_ok),
      .cap_in      (cap_w),
      .wide_in     (wide_w),
      .done        (probe_done),
      .ok          (probe_ok),
      .fault       (fault_code),
      .capacity    (capacity),
      .addr_bytes  (addr_bytes),
      .sn_present  (sn_present),
      .serial      (serial_num)
   );
endmodule

// File: rtl/fram_probe_chk.sv
module fram_probe_chk #(
   parameter int CAP_W = 20,
   parameter int SN_W  = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             spi_sclk,
   input logic             spi_cs_n,
   input logic             spi_mosi,
   input logic             spi_miso,
   input logic             probe_done,
   input logic             probe_ok,
   input logic [1:0]       fault_code,
   input logic [CAP_W-1:0] capacity,
   input logic [1:0]       addr_bytes,
   input logic             sn_present,
   input logic [SN_W-1:0]  serial_num
);
   // R2: the serial clock runs only inside a chip-select window
   assert_sclk_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);

   // R3: a fault is only reported once the probe is finished, and never with success
   assert_fault_final_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_code != 2'd0) |-> (probe_done && !probe_ok));

   // R7: a good capacity is a single power of two
   assert_cap_pow2_R7: assert property (@(posedge clk) disable iff (!rst_n)
      probe_ok |-> ($countones(capacity) == 1));

   // R8: the address width follows the capacity
   assert_addr_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
      probe_ok |-> ((addr_bytes == 2'd3) == (capacity > 65536)) &&
                   (addr_bytes >= 2'd2));

   // R10: without a serial number the register stays clear
   assert_sn_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !sn_present |-> (serial_num == '0));

   // R11: success implies completion, and results hold until the next start
   assert_ok_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      probe_ok |-> (probe_done && fault_code == 2'd0));

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_done && !start) |=> (probe_done && $stable(capacity) &&
                                  $stable(serial_num) && $stable(fault_code) &&
                                  spi_cs_n));
endmodule

bind fram_probe fram_probe_chk #(.CAP_W(CAP_W), .SN_W(8*SN_LEN)) chk_i (.*);

// File: tb/fram_probe_tb_top.sv
`timescale 1ns/100ps
module fram_probe_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        spi_sclk, spi_cs_n, spi_mosi;
   logic        spi_miso = 1'b0;
   logic        probe_done, probe_ok, sn_present;
   logic [1:0]  fault_code, addr_bytes;
   logic [19:0] capacity;
   logic [63:0] serial_num;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   fram_probe dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .probe_done(probe_done), .probe_ok(probe_ok),
      .fault_code(fault_code), .capacity(capacity), .addr_bytes(addr_bytes),
      .sn_present(sn_present), .serial_num(serial_num)
   );

   // ---------------- device model ----------------
   logic [7:0] m_sr;
   logic [7:0] m_id [9];
   logic [7:0] m_sn [8];
   logic [7:0] in_sh = '0;
   logic [7:0] opc = '0;
   int bitn = 0, byten = 0, cur = -1;
   int txn_cnt = 0;
   logic [7:0] txn_op [8];
   int txn_len [8];

   function automatic logic [7:0] resp(input logic [7:0] op, input int idx);
      if (idx == 0) return 8'h00;
      case (op)
         8'h05: return (idx == 1) ? m_sr : 8'h00;
         8'h9F: return (idx <= 9) ? m_id[idx-1] : 8'h00;
         8'hC3: return (idx <= 8) ? m_sn[idx-1] : 8'h00;
         default: return 8'h00;
      endcase
   endfunction

   always @(negedge spi_cs_n) begin
      bitn = 0; byten = 0; opc = 8'h00;
      cur = txn_cnt;
      txn_cnt = txn_cnt + 1;
      if (cur < 8) begin txn_op[cur] = 8'hxx; txn_len[cur] = 0; end
      spi_miso = 1'b0;
   end

   always @(posedge spi_cs_n) begin
      if (cur >= 0 && cur < 8) txn_len[cur] = byten;
   end

   always @(posedge spi_sclk) begin
      if (!spi_cs_n) in_sh = {in_sh[6:0], spi_mosi};
   end

   always @(negedge spi_sclk) begin
      if (!spi_cs_n) begin
         bitn = bitn + 1;
         if (bitn == 8) begin
            bitn = 0;
            if (byten == 0) begin
               opc = in_sh;
               if (cur >= 0 && cur < 8) txn_op[cur] = in_sh;
            end
            byten = byten + 1;
         end
         spi_miso = resp(opc, byten)[7-bitn];
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_probe(input logic [7:0] sr, input logic [7:0] b6, input logic [7:0] b7,
                           input logic [7:0] b8, input bit mid_start);
      int n;
      m_sr = sr;
      for (int i = 0; i < 6; i++) m_id[i] = 8'h7F;
      m_id[6] = b6; m_id[7] = b7; m_id[8] = b8;
      for (int i = 0; i < 8; i++) m_sn[i] = 8'(8'h11 * (i + 1));
      txn_cnt = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      n = 0;
      while (!probe_done && n < 4000) begin
         @(negedge clk);
         n++;
         if (mid_start && n == 100) start = 1'b1;
         else start = 1'b0;
      end
      start = 1'b0;
      chk("R11 probe completes", {63'd0, probe_done}, 64'd1);
   endtask

   function automatic logic [19:0] exp_cap(input logic [7:0] d);
      return 20'(1) << (d - 8'h21 + 8'd14);
   endfunction

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk("R1 cs_n", {63'd0, spi_cs_n}, 64'd1);
      chk("R1 sclk", {63'd0, spi_sclk}, 64'd0);
      chk("R1 done/ok/fault", {60'd0, probe_done, probe_ok, fault_code}, 64'd0);
      chk("R1 capacity/addr", {42'd0, capacity, addr_bytes}, 64'd0);
      chk("R1 serial", serial_num, 64'd0);
      chk("R1 sn_present", {63'd0, sn_present}, 64'd0);
   endtask

   task automatic t_busy();
      do_probe(8'h01, 8'hC2, 8'h22, 8'h00, 1'b0);
      chk("R2 status opcode", {56'd0, txn_op[0]}, 64'h05);
      chk("R2 status length", 64'(txn_len[0]), 64'd2);
      chk("R3 busy fault", {62'd0, fault_code}, 64'd1);
      chk("R3 ok low", {63'd0, probe_ok}, 64'd0);
      chk("R3 no further window", 64'(txn_cnt), 64'd1);
   endtask

   task automatic t_status_other_bits();
      do_probe(8'hFE, 8'hC2, 8'h21, 8'h00, 1'b0);
      chk("R3 other status bits ignored", {62'd0, fault_code}, 64'd0);
      chk("R4 ident opcode", {56'd0, txn_op[1]}, 64'h9F);
      chk("R4 ident length", 64'(txn_len[1]), 64'd10);
      chk("R7 capacity 0x21", {44'd0, capacity}, 64'(exp_cap(8'h21)));
      chk("R8 addr 0x21", {62'd0, addr_bytes}, 64'd2);
      chk("R10 no serial window", 64'(txn_cnt), 64'd2);
      chk("R11 ok", {63'd0, probe_ok}, 64'd1);
   endtask

   task automatic t_vendor();
      do_probe(8'h00, 8'hC1, 8'h22, 8'h01, 1'b0);
      chk("R5 vendor fault", {62'd0, fault_code}, 64'd2);
      chk("R5 stops after ident", 64'(txn_cnt), 64'd2);
      do_probe(8'h00, 8'h00, 8'h40, 8'h00, 1'b0);
      chk("R5 vendor beats density", {62'd0, fault_code}, 64'd2);
   endtask

   task automatic t_density();
      do_probe(8'h00, 8'hC2, 8'h20, 8'h00, 1'b0);
      chk("R6 density low", {62'd0, fault_code}, 64'd3);
      chk("R6 capacity stays 0", {44'd0, capacity}, 64'd0);
      do_probe(8'h00, 8'hC2, 8'h27, 8'h01, 1'b0);
      chk("R6 density high", {62'd0, fault_code}, 64'd3);
      chk("R6 no serial window", 64'(txn_cnt), 64'd2);
   endtask

   task automatic t_sizes();
      do_probe(8'h00, 8'hC2, 8'h23, 8'h00, 1'b0);
      chk("R7 capacity 64K", {44'd0, capacity}, 64'd65536);
      chk("R8 addr at 64K", {62'd0, addr_bytes}, 64'd2);
      do_probe(8'h00, 8'hC2, 8'h24, 8'h00, 1'b0);
      chk("R7 capacity 128K", {44'd0, capacity}, 64'd131072);
      chk("R8 addr above 64K", {62'd0, addr_bytes}, 64'd3);
      do_probe(8'h00, 8'hC2, 8'h26, 8'h00, 1'b0);
      chk("R7 capacity 512K", {44'd0, capacity}, 64'd524288);
      chk("R8 addr 512K", {62'd0, addr_bytes}, 64'd3);
   endtask

   task automatic t_serial();
      do_probe(8'h00, 8'hC2, 8'h22, 8'h5A, 1'b0);
      chk("R9 serial opcode", {56'd0, txn_op[2]}, 64'hC3);
      chk("R9 serial length", 64'(txn_len[2]), 64'd9);
      chk("R9 sn_present", {63'd0, sn_present}, 64'd1);
      chk("R9 serial order", serial_num, 64'h1122334455667788);
      chk("R9 ok", {63'd0, probe_ok}, 64'd1);
      chk("R7 capacity 32K", {44'd0, capacity}, 64'd32768);
      // a later probe without a serial number clears it
      do_probe(8'h00, 8'hC2, 8'h22, 8'h00, 1'b0);
      chk("R10 serial cleared", serial_num, 64'd0);
      chk("R10 sn_present low", {63'd0, sn_present}, 64'd0);
   endtask

   task automatic t_restart_ignored();
      do_probe(8'h00, 8'hC2, 8'h25, 8'h01, 1'b1);
      chk("R11 mid start ignored, windows", 64'(txn_cnt), 64'd3);
      chk("R11 mid start ignored, capacity", {44'd0, capacity}, 64'd262144);
      repeat (50) @(negedge clk);
      chk("R11 results hold", {42'd0, capacity, addr_bytes}, {42'd0, 20'd262144, 2'd3});
      chk("R11 done holds", {63'd0, probe_done}, 64'd1);
      chk("R11 serial holds", serial_num, 64'h1122334455667788);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      #1 t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_busy();
      t_status_other_bits();
      t_vendor();
      t_density();
      t_sizes();
      t_serial();
      t_restart_ignored();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_checks++;
      n_fail++;
      $display("FAIL R11 watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule